// File: doc/BRIEF.md
# Nibble-Parallel CRC-5 Generator

This block keeps a running 5-bit cyclic redundancy check over a data stream. Each clock it can absorb four message bits, so it replaces four one-bit shifts of a linear feedback register with one pass through a fixed XOR network. The generator polynomial is x^5 + x^2 + 1, the check used on short token-style packets. Each nibble enters most significant bit first.

A caller pulses `init_i` at the start of a message, which loads the state with all ones. It then presents one nibble per cycle on `data_i` with `valid_i` high. After the last nibble the running check value is on `crc_o`. The state is a plain register and `crc_o` is taken straight from it. A parameter can complement the value at the output for protocols that send the inverted remainder.

Top module: `crc5_nibble_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state becomes 5'h1F. With `OUT_INVERT`=0, `crc_o` reads 5'h1F from the cycle after that edge.
- R2: When `init_i` is high at a rising edge and `rst_i` is low, the state becomes 5'h1F. This holds whatever `valid_i` and `data_i` are, so data offered with init is ignored.
- R3: When `rst_i`, `init_i` and `valid_i` are all low at a rising edge, the state keeps its value and `crc_o` does not change.
- R4: On an accepted nibble d (valid high, init and reset low) with current state c, the next state n follows these equations:
  - n[1] = c[2]^d[1]
  - n[4] = c[0]^c[3]^d[2]
  - n[0] = c[1]^c[4]^d[0]^d[3]
  - n[3] = c[2]^c[4]^d[1]^d[3]
  - n[2] = c[1]^c[3]^c[4]^d[0]^d[2]^d[3]
- R5: One accepted nibble gives the same state as four serial steps. Each serial step works as follows:
  - take feedback f = c[4]^bit;
  - shift the state left by one, filling with 0;
  - XOR in 5'b00101 when f is 1.
  - The bits are fed in the order d[3], d[2], d[1], d[0].
- R6: `crc_o` reflects an accepted nibble one cycle after the edge that takes it. Back-to-back nibbles are each absorbed with no stall.
- R7: `rst_i` takes priority over `init_i` and `valid_i`. Both reset and init take priority over a data step.
- R8: With `OUT_INVERT`=1, `crc_o` is the bitwise complement of the state. After reset or init it reads 5'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset, loads the state with all ones |
| init_i | input | 1 | Synchronous start-of-message load of all ones |
| valid_i | input | 1 | Data strobe: absorb `data_i` this cycle |
| data_i | input | 4 | Message nibble, bit 3 is first in message order |
| crc_o | output | 5 | Registered check value, optionally complemented |

## Verification
A wrong term in one next-state equation corrupts the state on the first accepted nibble that exercises it. Because `crc_o` is the register itself, the error shows one cycle after that edge. After that the error spreads through later steps and never heals until the next init. The bench applies every nibble from the init state and every two-nibble pair. It then runs a long mixed stream with idle cycles and inits. It compares `crc_o` each cycle against both a bit-serial model and the written equations, so a faulty term, a wrong bit order or a missed hold is caught within a cycle of the first input that exposes it.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

  // Decoded per-cycle action for the state register.
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } crc_cmd_e;

  localparam int unsigned CRC5_WIDTH = 5;
  localparam int unsigned CRC5_NIBBLE = 4;
  localparam logic [CRC5_WIDTH-1:0] CRC5_POLY = 5'b00101;
  localparam logic [CRC5_WIDTH-1:0] CRC5_SEED = 5'b11111;

endpackage

// File: rtl/crc5_ctrl.sv
module crc5_ctrl
  import crc5_pkg::*;
(
  input  logic     rst_i,
  input  logic     init_i,
  input  logic     valid_i,
  output crc_cmd_e cmd_o
);

  // Reset and init both reseed; a data step only when neither is present.
  always_comb begin
    if (rst_i || init_i) begin
      cmd_o = CMD_LOAD;
    end else if (valid_i) begin
      cmd_o = CMD_STEP;
    end else begin
      cmd_o = CMD_HOLD;
    end
  end

endmodule

// File: rtl/crc5_par_next.sv
module crc5_par_next #(
  parameter int unsigned           CRC_W  = 5,
  parameter int unsigned           DATA_W = 4,
  parameter logic [CRC_W-1:0]      POLY   = 5'b00101
) (
  input  logic [CRC_W-1:0]  cur_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  nxt_o
);

  localparam bit USE_FIXED_EQ = (CRC_W == 5) && (DATA_W == 4) && (POLY == 5'b00101);

  // Bit-serial reference: MSB of the data word enters first.
  function automatic logic [CRC_W-1:0] serial_steps(
    input logic [CRC_W-1:0]  c,
    input logic [DATA_W-1:0] d
  );
    logic [CRC_W-1:0] s;
    logic             fb;
    s = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = s[CRC_W-1] ^ d[i];
      s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return s;
  endfunction

  logic [CRC_W-1:0] serial_ref;
  assign serial_ref = serial_steps(cur_i, data_i);

  generate
    if (USE_FIXED_EQ) begin : g_fixed
      // Flattened XOR network for x^5 + x^2 + 1, four bits per step.
      assign nxt_o[0] = cur_i[1] ^ cur_i[4] ^ data_i[0] ^ data_i[3];
      assign nxt_o[1] = cur_i[2] ^ data_i[1];
      assign nxt_o[2] = cur_i[1] ^ cur_i[3] ^ cur_i[4] ^ data_i[0] ^ data_i[2] ^ data_i[3];
      assign nxt_o[3] = cur_i[2] ^ cur_i[4] ^ data_i[1] ^ data_i[3];
      assign nxt_o[4] = cur_i[0] ^ cur_i[3] ^ data_i[2];

      always_comb begin
        if (!$isunknown({cur_i, data_i})) begin
          AST_XOR_MATCHES_SERIAL: assert (nxt_o == serial_ref); // R5
        end
      end
    end else begin : g_unrolled
      // Other polynomials or widths: let synthesis flatten the unrolled loop.
      assign nxt_o = serial_ref;
    end
  endgenerate

endmodule

// File: rtl/crc5_state_reg.sv
module crc5_state_reg
  import crc5_pkg::*;
#(
  parameter int unsigned      CRC_W = 5,
  parameter logic [CRC_W-1:0] SEED  = 5'b11111
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  crc_cmd_e         cmd_i,
  input  logic [CRC_W-1:0] nxt_i,
  output logic [CRC_W-1:0] state_o
);

  always_ff @(posedge clk_i) begin
    unique case (cmd_i)
      CMD_LOAD: state_o <= SEED;
      CMD_STEP: state_o <= nxt_i;
      default:  state_o <= state_o;
    endcase
  end

  AST_LOAD_SEEDS: assert property (@(posedge clk_i)
    (cmd_i == CMD_LOAD) |=> (state_o == SEED)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == CMD_HOLD) |=> $stable(state_o)); // R3

endmodule

// File: rtl/crc5_nibble_gen.sv
module crc5_nibble_gen
  import crc5_pkg::*;
#(
  parameter int unsigned      CRC_W      = CRC5_WIDTH,
  parameter int unsigned      DATA_W     = CRC5_NIBBLE,
  parameter logic [CRC_W-1:0] POLY       = CRC5_POLY,
  parameter logic [CRC_W-1:0] SEED       = CRC5_SEED,
  parameter bit               OUT_INVERT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              init_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  localparam logic [CRC_W-1:0] OUT_MASK = OUT_INVERT ? '1 : '0;

  crc_cmd_e         cmd;
  logic [CRC_W-1:0] state;
  logic [CRC_W-1:0] nxt;

  crc5_ctrl u_ctrl (
    .rst_i   (rst_i),
    .init_i  (init_i),
    .valid_i (valid_i),
    .cmd_o   (cmd)
  );

  crc5_par_next #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) u_next (
    .cur_i  (state),
    .data_i (data_i),
    .nxt_o  (nxt)
  );

  crc5_state_reg #(
    .CRC_W (CRC_W),
    .SEED  (SEED)
  ) u_state (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cmd_i   (cmd),
    .nxt_i   (nxt),
    .state_o (state)
  );

  // Output is the register itself, optionally complemented.
  assign crc_o = state ^ OUT_MASK;

  AST_RESET_SEED: assert property (@(posedge clk_i)
    rst_i |=> (crc_o == (SEED ^ OUT_MASK))); // R1

  AST_INIT_BEATS_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
    (init_i && valid_i) |=> (crc_o == (SEED ^ OUT_MASK))); // R7

endmodule

// File: tb/crc5_nibble_gen_bench.sv
module crc5_nibble_gen_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       init;
  logic       valid;
  logic [3:0] data;
  logic [4:0] crc;
  logic [4:0] crc_inv;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  int unsigned cycles = 0;
  logic [4:0]  model;

  always #4 clk = ~clk; // 125 MHz

  crc5_nibble_gen u_crc5_nibble_gen (
    .clk_i(clk), .rst_i(rst), .init_i(init), .valid_i(valid),
    .data_i(data), .crc_o(crc)
  );

  crc5_nibble_gen #(.OUT_INVERT(1'b1)) u_crc5_nibble_gen_inv (
    .clk_i(clk), .rst_i(rst), .init_i(init), .valid_i(valid),
    .data_i(data), .crc_o(crc_inv)
  );

  // Independent bit-serial model, d[3] first.
  function automatic logic [4:0] ser_model(input logic [4:0] c, input logic [3:0] d);
    logic [4:0] s;
    logic       f;
    s = c;
    for (int k = 3; k >= 0; k--) begin
      f = s[4] ^ d[k];
      s = {s[3:0], 1'b0};
      if (f) s = s ^ 5'b00101;
    end
    return s;
  endfunction

  function automatic logic [4:0] eq_model(input logic [4:0] c, input logic [3:0] d);
    logic [4:0] n;
    n[0] = c[1] ^ c[4] ^ d[0] ^ d[3];
    n[1] = c[2] ^ d[1];
    n[2] = c[1] ^ c[3] ^ c[4] ^ d[0] ^ d[2] ^ d[3];
    n[3] = c[2] ^ c[4] ^ d[1] ^ d[3];
    n[4] = c[0] ^ c[3] ^ d[2];
    return n;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic apply(input logic r, input logic in, input logic v,
                       input logic [3:0] d, input string tag);
    logic [4:0] exp;
    logic       stepped;
    rst = r; init = in; valid = v; data = d;
    stepped = 1'b0;
    if (r || in)  exp = 5'h1F;
    else if (v) begin
      exp = ser_model(model, d);
      stepped = 1'b1;
    end
    else          exp = model;
    @(negedge clk);
    check(tag, crc, exp);
    if (stepped) check("R4 equations", crc, eq_model(model, d));
    check("R8 inverted output", crc_inv, ~exp);
    model = exp;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] lcg;
    rst = 1'b1; init = 1'b0; valid = 1'b0; data = 4'h0;
    model = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", crc, 5'h1F);
    check("R8 reset inverted", crc_inv, 5'h00);

    // Every nibble from the seed (R5 single step).
    for (int d0 = 0; d0 < 16; d0++) begin
      apply(1'b0, 1'b1, 1'b0, 4'h0, "R2 init");
      apply(1'b0, 1'b0, 1'b1, 4'(d0), "R5 single nibble");
      apply(1'b0, 1'b0, 1'b0, 4'(d0 ^ 5), "R3 hold idle");
    end

    // Every pair of nibbles back to back (R6).
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(1'b0, 1'b1, 1'b1, 4'(b), "R2 init ignores data");
        apply(1'b0, 1'b0, 1'b1, 4'(a), "R6 first nibble");
        apply(1'b0, 1'b0, 1'b1, 4'(b), "R6 second nibble");
      end
    end

    // Priority corners (R7).
    apply(1'b0, 1'b0, 1'b1, 4'hA, "R5 step");
    apply(1'b1, 1'b1, 1'b1, 4'h3, "R7 reset over all");
    apply(1'b0, 1'b0, 1'b1, 4'h6, "R5 step");
    apply(1'b1, 1'b0, 1'b1, 4'h9, "R7 reset over valid");
    apply(1'b0, 1'b0, 1'b1, 4'hC, "R5 step");
    apply(1'b0, 1'b1, 1'b1, 4'hF, "R7 init over valid");

    // Long mixed stream.
    lcg = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:27] == 5'd0)
        apply(1'b0, 1'b1, lcg[5], lcg[11:8], "R2 init in stream");
      else if (lcg[26:24] == 3'd0)
        apply(1'b0, 1'b0, 1'b0, lcg[11:8], "R3 hold in stream");
      else
        apply(1'b0, 1'b0, 1'b1, lcg[11:8], "R5 stream step");
    end

    apply(1'b1, 1'b0, 1'b0, 4'h0, "R1 final reset");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule